// File: doc/BRIEF.md
# Key Wakeup Input Detector

This block watches a set of key pins on a slow sampling clock and raises a per-channel interrupt request when a pin reaches the active condition programmed for it. Each channel picks one of four conditions: high level, low level, rising edge or falling edge. Each channel also picks how its pad pull-up is driven. The pull-up can be held on at all times, or strobed on a fixed duty cycle so that the resistor draws current only for a short window in every detection cycle.

A free-running phase counter divides time into detection cycles of `CYC_LEN` sampling-clock periods. The pull-up window covers the first `WIN_LEN` periods of each cycle. Each pin is sampled once per cycle, on the clock edge one period before the window closes. Detection works only on these samples. A key must therefore stay active for at least one full cycle to be seen reliably, and detection can trail the key by up to one cycle. Edge conditions compare the new sample with the sample taken one cycle earlier. Each channel holds a sticky flag that drives its interrupt request until software pulses the channel's clear input.

Top module: `key_wake_detect`

## Requirements
- R1: Each channel's condition is a 2-bit field at bits [2i+1:2i] of `cond_sel`: 0 is high level, 1 is low level, 2 is rising edge, 3 is falling edge.
- R2: When a channel's `pu_dyn` bit is 0, its `pu_en` output is high in every cycle.
- R3: When a channel's `pu_dyn` bit is 1, its `pu_en` is high for phases 0 to `WIN_LEN`-1 of each `CYC_LEN`-period cycle and low for the rest. Phase 0 is the first period after reset is released.
- R4: A pin is sampled only on the clock edge that ends phase `WIN_LEN`-2. Pin values at any other time have no effect on the flags.
- R5: An edge condition is detected when the new sample differs from the sample taken one cycle earlier, in the selected direction.
- R6: A level condition sets the flag on every sample that matches the level, so the flag sets again after a clear while the level persists.
- R7: A flag stays set until the channel's `clr` bit is high at a clock edge. A clear and a detection at the same edge leave the flag set.
- R8: A channel whose `chan_en` bit is 0 never sets its flag.
- R9: Reset clears every flag and the phase counter. It loads each previous sample with the idle level (0 for high and rising, 1 for low and falling), so no edge is seen from the first sample.
- R10: A detected flag appears on `irq` right after the sampling edge, in phase `WIN_LEN`-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_in | input | N_KEYS | Key pin levels, synchronous to clk |
| cond_sel | input | 2*N_KEYS | Per-channel active condition, 2 bits each |
| pu_dyn | input | N_KEYS | Per-channel pull-up mode: 0 always on, 1 strobed |
| chan_en | input | N_KEYS | Per-channel detection enable |
| clr | input | N_KEYS | Per-channel flag clear, sampled each edge |
| pu_en | output | N_KEYS | Pull-up enable to the pads |
| irq | output | N_KEYS | Sticky interrupt requests |

## Verification
A phase counter that drifts or resets wrongly shows up first on the strobed `pu_en` outputs, within one window length. It also moves the edge at which `irq` rises away from phase `WIN_LEN`-1. A stale or wrongly reset previous sample shows up at the next sampling edge, as a missed or spurious edge flag, so at most one cycle after the stimulus. A flag that clears or sets on the wrong terms is visible on `irq` at the end of the same cycle. The bench checks that cycle after every vector.

// File: rtl/kwd_pkg.sv
// Shared types for the key wakeup detector.
package kwd_pkg;

    // Active condition encoding, fixed by the cond_sel field layout.
    typedef enum logic [1:0] {
        COND_HIGH = 2'd0,
        COND_LOW  = 2'd1,
        COND_RISE = 2'd2,
        COND_FALL = 2'd3
    } cond_e;

    // Idle pin level for a condition; used to seed the previous sample.
    function automatic logic idle_level(input cond_e c);
        return (c == COND_LOW) || (c == COND_FALL);
    endfunction

endpackage

// File: rtl/kwd_phase.sv
// Phase counter for the detection cycle.
// Produces the pull-up window (phases 0..WIN_LEN-1) and a one-period
// strobe during phase WIN_LEN-2, so the pins are sampled on the edge one
// period before the window closes.
// Assumes 2 <= WIN_LEN < CYC_LEN.
module kwd_phase #(
    parameter int WIN_LEN = 4,
    parameter int CYC_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic win,
    output logic stb
);
    localparam int PW = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;

    logic [PW-1:0] phase_q;

    if (WIN_LEN < 2 || WIN_LEN >= CYC_LEN) begin : g_bad_cfg
        $error("kwd_phase: WIN_LEN must be >= 2 and < CYC_LEN");
    end

    // Advance the phase, wrapping at the end of each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == PW'(CYC_LEN - 1))
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    // Decode the window and the sampling strobe from the phase.
    always_comb begin
        win = (phase_q < PW'(WIN_LEN));
        stb = (phase_q == PW'(WIN_LEN - 2));
    end

endmodule

// File: rtl/kwd_chan.sv
// One key channel: samples the pin on the strobe, evaluates the
// programmed condition against the current and previous samples, and
// holds a sticky flag until cleared. Also muxes the pull-up enable.
// Assumes key is already synchronous to clk.
module kwd_chan
    import kwd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  key,
    input  cond_e cond,
    input  logic  dyn,
    input  logic  en,
    input  logic  clr,
    input  logic  win,
    input  logic  stb,
    output logic  pu_en,
    output logic  flag
);
    logic prev_q;
    logic hit;

    // Evaluate the active condition on the live pin and the last sample.
    always_comb begin
        case (cond)
            COND_HIGH: hit = key;
            COND_LOW:  hit = !key;
            COND_RISE: hit = key && !prev_q;
            COND_FALL: hit = !key && prev_q;
            default:   hit = 1'b0;
        endcase
    end

    // Keep the previous sample, seeded with the idle level on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= idle_level(cond);
        else if (stb)
            prev_q <= key;
    end

    // Sticky flag: a detection wins over a clear at the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else
            flag <= (flag && !clr) || (stb && en && hit);
    end

    // Strobed pull-up follows the window; static pull-up stays on.
    always_comb pu_en = dyn ? win : 1'b1;

endmodule

// File: rtl/key_wake_detect.sv
// Key wakeup detector top: one shared phase counter feeding N_KEYS
// identical channels. All inputs are synchronous to clk.
module key_wake_detect
    import kwd_pkg::*;
#(
    parameter int N_KEYS  = 4,
    parameter int WIN_LEN = 4,
    parameter int CYC_LEN = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_KEYS-1:0]     key_in,
    input  logic [2*N_KEYS-1:0]   cond_sel,
    input  logic [N_KEYS-1:0]     pu_dyn,
    input  logic [N_KEYS-1:0]     chan_en,
    input  logic [N_KEYS-1:0]     clr,
    output logic [N_KEYS-1:0]     pu_en,
    output logic [N_KEYS-1:0]     irq
);
    logic win;
    logic stb;

    kwd_phase #(.WIN_LEN(WIN_LEN), .CYC_LEN(CYC_LEN)) phase_i (
        .clk   (clk),
        .rst_n (rst_n),
        .win   (win),
        .stb   (stb)
    );

    for (genvar g = 0; g < N_KEYS; g++) begin : g_chan
        kwd_chan chan_i (
            .clk   (clk),
            .rst_n (rst_n),
            .key   (key_in[g]),
            .cond  (cond_e'(cond_sel[2*g +: 2])),
            .dyn   (pu_dyn[g]),
            .en    (chan_en[g]),
            .clr   (clr[g]),
            .win   (win),
            .stb   (stb),
            .pu_en (pu_en[g]),
            .flag  (irq[g])
        );
    end

endmodule

// File: rtl/kwd_chk.sv
// Protocol checker for key_wake_detect. Keeps its own phase count from
// reset and relates the pull-up and interrupt outputs to it.
module kwd_chk #(
    parameter int N_KEYS  = 4,
    parameter int WIN_LEN = 4,
    parameter int CYC_LEN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_KEYS-1:0] pu_dyn,
    input logic [N_KEYS-1:0] chan_en,
    input logic [N_KEYS-1:0] clr,
    input logic [N_KEYS-1:0] pu_en,
    input logic [N_KEYS-1:0] irq
);
    int cnt;

    // Independent phase reference.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= 0;
        else
            cnt <= (cnt == CYC_LEN - 1) ? 0 : cnt + 1;
    end

    for (genvar i = 0; i < N_KEYS; i++) begin : g_c
        // R2
        static_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pu_dyn[i] |-> pu_en[i]);
        // R3
        dyn_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pu_dyn[i] |-> (pu_en[i] == (cnt < WIN_LEN)));
        // R10
        rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> (cnt == WIN_LEN - 1));
        // R7
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] && !clr[i] |=> irq[i]);
        // R8
        disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_en[i] && !irq[i] |=> !irq[i]);
        // R9
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> !irq[i]);
    end

endmodule

bind key_wake_detect kwd_chk #(
    .N_KEYS(N_KEYS), .WIN_LEN(WIN_LEN), .CYC_LEN(CYC_LEN)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pu_dyn  (pu_dyn),
    .chan_en (chan_en),
    .clr     (clr),
    .pu_en   (pu_en),
    .irq     (irq)
);

// File: tb/key_wake_detect_tb_top.sv
`timescale 1ns/1ps
module key_wake_detect_tb_top;
    localparam int N  = 4;
    localparam int W  = 4;
    localparam int C  = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] key_in = 4'b1010;
    logic [7:0]   cond_sel = 8'b11_10_01_00;  // ch3 fall, ch2 rise, ch1 low, ch0 high (R1)
    logic [N-1:0] pu_dyn = 4'b0101;
    logic [N-1:0] chan_en = 4'b1111;
    logic [N-1:0] clr = 4'b0000;
    logic [N-1:0] pu_en;
    logic [N-1:0] irq;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    key_wake_detect #(.N_KEYS(N), .WIN_LEN(W), .CYC_LEN(C)) dut_i (
        .clk(clk), .rst_n(rst_n), .key_in(key_in), .cond_sel(cond_sel),
        .pu_dyn(pu_dyn), .chan_en(chan_en), .clr(clr),
        .pu_en(pu_en), .irq(irq)
    );

    typedef struct packed {
        logic [3:0] key;
        logic [3:0] clr;
        logic [3:0] exp;
    } vec_t;

    // Each vector spans one detection cycle; clr is pulsed in phase 0.
    localparam vec_t VECS [12] = '{
        '{4'b1010, 4'b0000, 4'b0000},  // idle, no spurious edge (R9, R5)
        '{4'b1010, 4'b0000, 4'b0000},  // still idle
        '{4'b1011, 4'b0000, 4'b0001},  // ch0 high level (R1, R6)
        '{4'b1010, 4'b0000, 4'b0001},  // sticky (R7)
        '{4'b1010, 4'b0001, 4'b0000},  // cleared (R7)
        '{4'b1110, 4'b0000, 4'b0100},  // ch2 rising edge (R5)
        '{4'b1110, 4'b0100, 4'b0000},  // no second rise while high (R5)
        '{4'b0110, 4'b0000, 4'b1000},  // ch3 falling edge (R5)
        '{4'b0000, 4'b1000, 4'b0010},  // ch1 low level (R6)
        '{4'b0000, 4'b0010, 4'b0010},  // level re-sets after clear (R6)
        '{4'b1010, 4'b1111, 4'b0000},  // wrong directions ignored (R5)
        '{4'b1111, 4'b0000, 4'b0101}   // ch0 level and ch2 rise together
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Run one cycle from a phase-0 negedge; optionally check pull-up shape.
    task automatic run_cycle(input logic [3:0] k, input logic [3:0] c, input bit chk_pu);
        int cnt_dyn = 0;
        int cnt_stat = 0;
        key_in = k;
        clr = c;
        for (int p = 0; p < C; p++) begin
            if (pu_en[0]) cnt_dyn++;
            if (pu_en[1]) cnt_stat++;
            if (chk_pu && p == 0) check("R3 window open at phase 0", pu_en, 4'b1111);
            if (chk_pu && p == W) check("R3 window closed at phase W", pu_en, 4'b1010);
            @(negedge clk);
            clr = 4'b0000;
        end
        if (chk_pu) begin
            check_int("R3 strobed pull-up high count", cnt_dyn, W);
            check_int("R2 static pull-up high count", cnt_stat, C);
        end
    endtask

    // Custom cycles on ch0: 0 pulse only at sample, 1 high except at sample,
    // 2 held high with a clear at the sampling edge.
    task automatic run_ch0(input int kind);
        for (int p = 0; p < C; p++) begin
            key_in = 4'b1010;
            clr    = 4'b0000;
            case (kind)
                0: key_in[0] = (p == W - 2);
                1: key_in[0] = (p != W - 2);
                default: begin
                    key_in[0] = 1'b1;
                    clr[0]    = (p == W - 2);
                end
            endcase
            if (kind == 0 && p == W - 2) check("R10 no flag before sampling edge", irq, 4'b0000);
            if (kind == 0 && p == W - 1) check("R10 flag right after sampling edge", irq, 4'b0001);
            @(negedge clk);
        end
        key_in = 4'b1010;
        clr    = 4'b0000;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 irq clear in reset", irq, 4'b0000);
        check("R2 R3 pull-ups on in reset", pu_en, 4'b1111);
        rst_n = 1'b1;

        for (int v = 0; v < 12; v++) begin
            run_cycle(VECS[v].key, VECS[v].clr, v == 0);
            check($sformatf("R1 R5 R6 R7 vector %0d", v), irq, VECS[v].exp);
        end

        // Clear everything and return to idle.
        run_cycle(4'b1010, 4'b1111, 1'b0);
        check("R7 all cleared", irq, 4'b0000);

        // R4: a pulse present only at the sampling edge is seen.
        run_ch0(0);
        check("R4 pulse at sample point detected", irq, 4'b0001);
        run_cycle(4'b1010, 4'b0001, 1'b0);
        check("R7 clear after pulse", irq, 4'b0000);

        // R4: high everywhere except the sampling edge is ignored.
        run_ch0(1);
        check("R4 activity off the sample point ignored", irq, 4'b0000);

        // R7: clear and detection at the same edge leave the flag set.
        run_ch0(2);
        check("R7 detect wins over same-edge clear", irq, 4'b0001);
        run_cycle(4'b1010, 4'b0001, 1'b0);
        check("R7 later clear works", irq, 4'b0000);

        // R8: disabled channel does not flag.
        chan_en = 4'b1110;
        run_cycle(4'b1011, 4'b0000, 1'b0);
        check("R8 disabled channel quiet", irq, 4'b0000);
        chan_en = 4'b1111;
        run_cycle(4'b1011, 4'b0000, 1'b0);
        check("R8 re-enabled channel flags", irq, 4'b0001);

        // R9: mid-run reset clears flags; no edge seen from idle pins.
        rst_n  = 1'b0;
        key_in = 4'b1010;
        repeat (2) @(negedge clk);
        check("R9 reset clears flags", irq, 4'b0000);
        rst_n = 1'b1;
        run_cycle(4'b1010, 4'b0000, 1'b0);
        check("R9 no spurious edge after reset", irq, 4'b0000);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule